// File: doc/BRIEF.md
# Device-Addressed Bus Move Controller

This block executes 16-bit instruction words for a small CPU built around one shared data bus. It holds fifteen 16-bit device registers, numbered 1 to 15, plus a device 0 that always reads as zero. A move instruction names a source device and a destination device with one hex digit each. In the same cycle, the block places the source on the bus and loads the destination from it.

When the top bit of an instruction is set, the word is a jump into firmware space. The block saves the current firmware pointer into the firmware return register and loads the pointer with the 15-bit address, zero-extended to 16 bits.

Each instruction comes with a 4-bit condition selector and a carry flag. These can suppress a move. The program counter is device 1. It advances on its own after every executed instruction that is not a firmware jump, unless the instruction wrote device 1 itself. A debug read port with a one-cycle latency exposes every device.

Top module: `bus_move_ctrl`

## Requirements
- R1: An instruction presented with `instr_valid` high is captured on one rising edge and executed on the next one. Its register and flag results are visible after that second edge.
- R2: A word with bit 15 = 0 and bits 11:8 = 4'b1010 is a move. The device in bits 7:4 is copied into the device in bits 3:0, and the source keeps its value.
- R3: Device 0 always reads as zero, both as a move source and on the read port. A move into device 0 changes no register.
- R4: A condition selector of 4'b0000 always executes. A selector of 4'b0001 executes only if `carry_in` was high with the instruction. Every other selector value never executes a move.
- R5: A move whose condition is false changes no device register other than the program counter, which advances by one.
- R6: A word with bit 15 = 1 copies device 3 into device 4 and loads device 3 with {1'b0, bits 14:0}. It leaves the program counter unchanged and pulses `fw_entry_o` for exactly one cycle.
- R7: A word with bit 15 = 0 whose bits 11:8 are not 4'b1010 changes no device register other than the program counter, which advances by one. It pulses `illegal_o` for exactly one cycle.
- R8: The program counter (device 1) advances by one after each executed instruction other than a firmware jump. A cycle with no instruction leaves it unchanged. An executed move into device 1 loads the program counter with the moved value instead of advancing it.
- R9: In a word with bit 15 = 0, bits 14:12 have no effect on decoding.
- R10: While `rst` is high, on a rising edge, every device register, `illegal_o` and `fw_entry_o` clear to zero.
- R11: `rd_data` shows the device selected by `rd_sel` at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| cond_sel | input | 4 | Condition selector for this instruction |
| carry_in | input | 1 | Carry flag for this instruction |
| rd_sel | input | 4 | Device number for the debug read port |
| rd_data | output | 16 | Registered contents of the selected device |
| pc_o | output | 16 | Current program counter (device 1) |
| illegal_o | output | 1 | One-cycle pulse for an unrecognised microcode opcode |
| fw_entry_o | output | 1 | One-cycle pulse for a firmware jump |

## Verification
Values can only enter the devices through firmware jumps, so the walked vectors first load distinct addresses and then spread them with moves. Moves are tried with the condition always true, with the carry condition under both carry levels, and with an undefined selector. Together these separate a correct condition gate from one that ignores the selector or the carry. Moves into device 0, moves out of device 0, and a word with nonzero bits 14:12 separate a hardwired zero from a stored one and show that the ignored bits are truly ignored. A move into the program counter and a move out of it show whether auto-increment is correctly overridden and whether the source is read before the increment. Back-to-back words, idle cycles and a mid-run reset cover the pipeline timing.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;
  localparam int INSTR_W  = 16;
  localparam int FIELD_W  = 4;
  localparam logic [FIELD_W-1:0] OP_MOVE = 4'hA;
  localparam logic [FIELD_W-1:0] CC_ALWAYS = 4'h0;
  localparam logic [FIELD_W-1:0] CC_CARRY  = 4'h1;
  localparam int DEV_PC  = 1;
  localparam int DEV_FWP = 3;
  localparam int DEV_FWR = 4;

  typedef enum logic [1:0] {
    K_MOVE  = 2'd0,
    K_FIRM  = 2'd1,
    K_ILL   = 2'd2
  } instr_kind_e;
endpackage

// File: rtl/bmc_decode.sv
`timescale 1ns/1ps
module bmc_decode
  import bmc_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic [INSTR_W-1:0] ir,
  output instr_kind_e        kind,
  output logic [ID_W-1:0]    src,
  output logic [ID_W-1:0]    dst,
  output logic [DATA_W-1:0]  fw_addr
);
  localparam int ADDR_W = INSTR_W - 1;
  localparam int OP_LSB = 2 * ID_W;

  always_comb begin
    src     = ir[2*ID_W-1:ID_W];
    dst     = ir[ID_W-1:0];
    fw_addr = DATA_W'(ir[ADDR_W-1:0]);
    if (ir[INSTR_W-1])
      kind = K_FIRM;
    else if (ir[OP_LSB+FIELD_W-1:OP_LSB] == OP_MOVE)
      kind = K_MOVE;
    else
      kind = K_ILL;
  end
endmodule

// File: rtl/bmc_cond.sv
`timescale 1ns/1ps
module bmc_cond
  import bmc_pkg::*;
(
  input  logic [FIELD_W-1:0] sel,
  input  logic               carry,
  output logic               ok
);
  always_comb begin
    unique case (sel)
      CC_ALWAYS: ok = 1'b1;
      CC_CARRY:  ok = carry;
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/bmc_devbank.sv
`timescale 1ns/1ps
module bmc_devbank
  import bmc_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   src_sel,
  output logic [DATA_W-1:0] bus,
  input  logic              we,
  input  logic [ID_W-1:0]   wr_sel,
  input  logic              pc_adv,
  input  logic              fw_go,
  input  logic [DATA_W-1:0] fw_addr,
  input  logic [ID_W-1:0]   rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pc
);
  localparam int NDEV = 1 << ID_W;

  logic [DATA_W-1:0] dev_all [NDEV];

  assign dev_all[0] = '0;
  assign bus        = dev_all[src_sel];
  assign pc         = dev_all[DEV_PC];

  for (genvar i = 1; i < NDEV; i++) begin : g_dev
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;
    logic              hit;
    assign hit = we && (wr_sel == ID_W'(i));

    if (i == DEV_PC) begin : g_pc
      always_comb d = hit ? bus : (pc_adv ? q + DATA_W'(1) : q);
    end else if (i == DEV_FWP) begin : g_fwp
      always_comb d = fw_go ? fw_addr : (hit ? bus : q);
    end else if (i == DEV_FWR) begin : g_fwr
      always_comb d = fw_go ? dev_all[DEV_FWP] : (hit ? bus : q);
    end else begin : g_plain
      always_comb d = hit ? bus : q;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
    assign dev_all[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= dev_all[rd_sel];
  end

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == '0) |=> (rd_data == '0)); // R3
  AST_FW_SAVE: assert property (@(posedge clk) disable iff (rst)
    fw_go |=> (dev_all[DEV_FWR] == $past(dev_all[DEV_FWP]))); // R6
  AST_FW_LOAD: assert property (@(posedge clk) disable iff (rst)
    fw_go |=> (dev_all[DEV_FWP] == $past(fw_addr))); // R6
endmodule

// File: rtl/bus_move_ctrl.sv
`timescale 1ns/1ps
module bus_move_ctrl
  import bmc_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [3:0]        cond_sel,
  input  logic              carry_in,
  input  logic [ID_W-1:0]   rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pc_o,
  output logic              illegal_o,
  output logic              fw_entry_o
);
  logic [INSTR_W-1:0] ir_q;
  logic [FIELD_W-1:0] cond_q;
  logic               carry_q;
  logic               vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q    <= '0;
      cond_q  <= '0;
      carry_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= instr_valid;
      if (instr_valid) begin
        ir_q    <= instr;
        cond_q  <= cond_sel;
        carry_q <= carry_in;
      end
    end
  end

  instr_kind_e       kind;
  logic [ID_W-1:0]   src, dst;
  logic [DATA_W-1:0] fw_addr;
  logic              cond_ok;

  bmc_decode #(.ID_W(ID_W), .DATA_W(DATA_W)) u_dec (
    .ir(ir_q), .kind(kind), .src(src), .dst(dst), .fw_addr(fw_addr)
  );

  bmc_cond u_cond (.sel(cond_q), .carry(carry_q), .ok(cond_ok));

  logic do_move, we, pc_adv, fw_go;
  assign do_move = vld_q && (kind == K_MOVE) && cond_ok;
  assign we      = do_move && (dst != '0);
  assign fw_go   = vld_q && (kind == K_FIRM);
  assign pc_adv  = vld_q && !fw_go && !(we && dst == ID_W'(DEV_PC));

  logic [DATA_W-1:0] bus;

  bmc_devbank #(.ID_W(ID_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .src_sel(src), .bus(bus), .we(we), .wr_sel(dst),
    .pc_adv(pc_adv), .fw_go(fw_go), .fw_addr(fw_addr),
    .rd_sel(rd_sel), .rd_data(rd_data), .pc(pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_o  <= 1'b0;
      fw_entry_o <= 1'b0;
    end else begin
      illegal_o  <= vld_q && (kind == K_ILL);
      fw_entry_o <= fw_go;
    end
  end

  AST_FALSE_COND_PC: assert property (@(posedge clk) disable iff (rst)
    (vld_q && kind == K_MOVE && !cond_ok) |=> (pc_o == $past(pc_o) + DATA_W'(1))); // R5
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (vld_q && kind == K_ILL) |=> (illegal_o && pc_o == $past(pc_o) + DATA_W'(1))); // R7
  AST_FW_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    fw_go |=> (fw_entry_o && $stable(pc_o))); // R6
  AST_IDLE_PC: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> $stable(pc_o)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({illegal_o, fw_entry_o})); // R7
endmodule

// File: tb/tb_bus_move_ctrl.sv
`timescale 1ns/1ps
module tb_bus_move_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  cond_sel = '0;
  logic        carry_in = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_data, pc_o;
  logic        illegal_o, fw_entry_o;

  always #4 clk = ~clk;

  bus_move_ctrl dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .cond_sel(cond_sel), .carry_in(carry_in), .rd_sel(rd_sel),
    .rd_data(rd_data), .pc_o(pc_o), .illegal_o(illegal_o), .fw_entry_o(fw_entry_o)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] m [16];
  logic exp_ill, exp_fw;

  // {cond[3:0], carry, instr[15:0]}
  localparam logic [20:0] VEC [12] = '{
    {4'h0, 1'b0, 16'h8123},  // R6 jump, fw ptr <- 0x0123
    {4'h0, 1'b0, 16'h0A37},  // R2 move 3 -> 7
    {4'h0, 1'b0, 16'hFFFF},  // R6 jump, return <- 0x0123
    {4'h1, 1'b0, 16'h0A39},  // R4 carry low: suppressed
    {4'h1, 1'b1, 16'h0A39},  // R4 carry high: executes
    {4'h0, 1'b0, 16'h0A40},  // R3 write to device 0
    {4'h0, 1'b0, 16'h0A07},  // R3 read of device 0
    {4'h0, 1'b0, 16'h0B12},  // R7 illegal opcode
    {4'h0, 1'b0, 16'h7A49},  // R9 bits 14:12 set
    {4'h5, 1'b1, 16'h0A38},  // R4 undefined selector
    {4'h0, 1'b0, 16'h0A91},  // R8 move into PC
    {4'h0, 1'b0, 16'h0A16}   // R8 move out of PC
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = '0;
  endtask

  task automatic model_step(input logic [3:0] c, input logic cy, input logic [15:0] w);
    logic ok;
    logic [15:0] v;
    exp_ill = 1'b0;
    exp_fw  = 1'b0;
    if (w[15]) begin
      m[4] = m[3];
      m[3] = {1'b0, w[14:0]};
      exp_fw = 1'b1;
    end else if (w[11:8] == 4'hA) begin
      ok = (c == 4'h0) || (c == 4'h1 && cy);
      v  = m[w[7:4]];
      if (ok && w[3:0] != 4'h0) m[w[3:0]] = v;
      if (!(ok && w[3:0] == 4'h1)) m[1] = m[1] + 16'd1;
    end else begin
      exp_ill = 1'b1;
      m[1] = m[1] + 16'd1;
    end
    m[0] = '0;
  endtask

  task automatic issue(input logic [3:0] c, input logic cy, input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr = w; cond_sel = c; carry_in = cy;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic read_dev(input logic [3:0] id, output logic [15:0] v);
    @(negedge clk);
    rd_sel = id;
    @(posedge clk);
    #1 v = rd_data;
  endtask

  task automatic check_all_devs(input string req);
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      read_dev(4'(i), v);
      check(i == 0 ? "R3" : req, $sformatf("dev%0d", i), v, m[i]);
    end
  endtask

  task automatic run_one(input logic [3:0] c, input logic cy, input logic [15:0] w);
    issue(c, cy, w);
    model_step(c, cy, w);
    @(posedge clk);  // execute edge (R1)
    #1;
    check("R8", "pc", pc_o, m[1]);
    check("R7", "illegal_o", {15'd0, illegal_o}, {15'd0, exp_ill});
    check("R6", "fw_entry_o", {15'd0, fw_entry_o}, {15'd0, exp_fw});
    @(posedge clk);
    #1;
    check("R7", "illegal pulse end", {15'd0, illegal_o}, 16'd0);
    check("R6", "fw pulse end", {15'd0, fw_entry_o}, 16'd0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R10 reset state
    check("R10", "pc after reset", pc_o, 16'd0);
    check("R10", "illegal after reset", {15'd0, illegal_o}, 16'd0);
    check("R10", "fw after reset", {15'd0, fw_entry_o}, 16'd0);
    check_all_devs("R10");

    // table walk; R2 and R11 through register reads
    for (int k = 0; k < 12; k++) begin
      run_one(VEC[k][20:17], VEC[k][16], VEC[k][15:0]);
      check_all_devs("R2");
    end

    // R8 idle cycles leave PC alone
    repeat (4) @(posedge clk);
    #1 check("R8", "pc idle", pc_o, m[1]);

    // R1 back-to-back: second move sees first one's write
    @(negedge clk);
    instr_valid = 1'b1; instr = 16'h0A35; cond_sel = 4'h0; carry_in = 1'b0;
    model_step(4'h0, 1'b0, 16'h0A35);
    @(negedge clk);
    instr = 16'h0A52;
    model_step(4'h0, 1'b0, 16'h0A52);
    @(negedge clk);
    instr_valid = 1'b0;
    @(posedge clk);
    #1 check("R1", "pc after pair", pc_o, m[1]);
    read_dev(4'd2, v);
    check("R1", "dev2 via forwarded write", v, m[2]);
    read_dev(4'd5, v);
    check("R1", "dev5", v, m[5]);

    // R1 timing: no effect after the capture edge alone
    @(negedge clk);
    instr_valid = 1'b1; instr = 16'h8055; cond_sel = 4'h0;
    @(posedge clk);
    #1 check("R1", "fw flag not yet", {15'd0, fw_entry_o}, 16'd0);
    @(negedge clk) instr_valid = 1'b0;
    model_step(4'h0, 1'b0, 16'h8055);
    @(posedge clk);
    #1 check("R1", "fw flag at execute", {15'd0, fw_entry_o}, 16'd1);
    read_dev(4'd3, v);
    check("R6", "fw ptr", v, 16'h0055);

    // R11 read port latency: value follows selection after one edge
    @(negedge clk) rd_sel = 4'd4;
    @(posedge clk);
    #1 check("R11", "dev4 read", rd_data, m[4]);

    // R10 mid-run reset
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    model_reset();
    #1 check("R10", "pc after second reset", pc_o, 16'd0);
    check_all_devs("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule